// File: doc/BRIEF.md
# Configurable GPIO Pin Control Cell

This cell controls a bank of general-purpose pins. Each pin owns one bit in each of several control registers. One bit decides who drives the pad: software, through an output-value register, or an on-chip peripheral, through its own data and enable signals. The chosen value can be inverted before it reaches the pad. A pad is either driven or left at high impedance.

Coming in, each pad level passes through a two-stage synchronizer. An input-enable bit then gates it before it reaches software or the peripheral. A per-pin open-drain bit lets a pin behave like a wired-AND line: it only ever pulls low, and it releases the pad so that an external pull-up makes the high.

Software reaches the registers through a simple word-indexed write/read port. Reads are combinational, and a write lands on the next rising clock edge.

Top module: `gpio_bank_ctl`

## Requirements
- R1: A pin whose function bit (register index 5) is 0 takes its output value from the output-value register (index 3) and its enable from the output-enable register (index 2). A pin whose function bit is 1 takes both from `per_out` and `per_oe`. The unused source has no effect on the pad.
- R2: A pin whose input-enable bit (index 1) is 0 shows 0 in the input value (index 0) and on `per_in`, whatever the pad level. When the bit is 1, both show the synchronized pad level.
- R3: A pad level present before a rising edge is still absent from the input value after that edge. It appears after the second edge.
- R4: A pin whose invert bit (index 4) is 1 drives the complement of its selected output value. This holds in both software and peripheral mode.
- R5: A pin whose selected enable is 0 has `pad_oe` low (high impedance). When the selected enable is 1, `pad_oe` is high.
- R6: A pin whose open-drain bit (index 6) is 1 has `pad_out` at 0. Its `pad_oe` is high only when the selected enable is 1 and the inverted-as-configured value is 0. A 1 releases the pad.
- R7: The registers sit at word indices 0 (input value, read-only; writes to it are ignored), 1 (input enable), 2 (output enable), 3 (output value), 4 (invert), 5 (function), 6 (open-drain). A write with `reg_wr_en` high is readable after the next rising edge. Index 7 reads as 0.
- R8: While `rst_n` is low at a rising edge, every register clears to 0. Every pin is then an undriven GPIO with its input disabled, and the input value reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | 32 | Level observed on each pad |
| pad_out | output | 32 | Value driven toward each pad |
| pad_oe | output | 32 | Per-pad drive enable, 0 is high impedance |
| per_out | input | 32 | Peripheral output values |
| per_oe | input | 32 | Peripheral output enables |
| per_in | output | 32 | Gated, synchronized pad levels toward the peripheral |

## Verification
The hardest situation to reach from the ports is one where every control bit matters at once. An example is a peripheral-owned, inverted pin whose level loops back through the pad and the synchronizer into a gated read. A wrong source, a missing inversion or a missing gate there can cancel out or be hidden by the pad. The bench therefore models the pad as driven-or-pulled-up and walks pin 0 through all sixteen settings of function, input enable, invert and output enable, with two data values each. In peripheral mode the unused software registers hold the opposite values, so taking the wrong source shows up.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register index type for the GPIO pin control cell.
// Assumes word-indexed register access; indices are part of the software contract.
package gpio_bank_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_VALUE = 3'd0,
        RA_IE    = 3'd1,
        RA_OE    = 3'd2,
        RA_OVAL  = 3'd3,
        RA_INV   = 3'd4,
        RA_FUNC  = 3'd5,
        RA_OD    = 3'd6,
        RA_NONE  = 3'd7
    } gb_reg_e;

endpackage

// File: rtl/gpio_bank_regs.sv
// Module: per-pin control register file with one bit per pin in each register.
// Assumes NPINS <= DATA_W; the input-value index is read-only and its writes are dropped.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NPINS-1:0]      in_value,
    output logic [NPINS-1:0]      ie_q,
    output logic [NPINS-1:0]      oe_q,
    output logic [NPINS-1:0]      oval_q,
    output logic [NPINS-1:0]      inv_q,
    output logic [NPINS-1:0]      func_q,
    output logic [NPINS-1:0]      od_q,
    output logic [DATA_W-1:0]     rdata
);

    logic [NPINS-1:0] wbits;
    assign wbits = wdata[NPINS-1:0];

    // Update the addressed control register on a write; clear all under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= '0;
            oe_q   <= '0;
            oval_q <= '0;
            inv_q  <= '0;
            func_q <= '0;
            od_q   <= '0;
        end else if (wr_en) begin
            case (gb_reg_e'(addr))
                RA_IE:   ie_q   <= wbits;
                RA_OE:   oe_q   <= wbits;
                RA_OVAL: oval_q <= wbits;
                RA_INV:  inv_q  <= wbits;
                RA_FUNC: func_q <= wbits;
                RA_OD:   od_q   <= wbits;
                default: ;
            endcase
        end
    end

    // Select the register image for the current read index.
    always_comb begin
        rdata = '0;
        case (gb_reg_e'(addr))
            RA_VALUE: rdata[NPINS-1:0] = in_value;
            RA_IE:    rdata[NPINS-1:0] = ie_q;
            RA_OE:    rdata[NPINS-1:0] = oe_q;
            RA_OVAL:  rdata[NPINS-1:0] = oval_q;
            RA_INV:   rdata[NPINS-1:0] = inv_q;
            RA_FUNC:  rdata[NPINS-1:0] = func_q;
            RA_OD:    rdata[NPINS-1:0] = od_q;
            default:  rdata = '0;
        endcase
    end

    // R7: a write to the output-enable index is held after the edge.
    p_oe_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && gb_reg_e'(addr) == RA_OE) |=> (oe_q == $past(wbits)));

    // R7: a write to the read-only index leaves every control register unchanged.
    p_value_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && gb_reg_e'(addr) == RA_VALUE) |=>
        ($stable(ie_q) && $stable(oe_q) && $stable(oval_q) &&
         $stable(inv_q) && $stable(func_q) && $stable(od_q)));

endmodule

// File: rtl/gpio_bank_sync.sv
// Module: two-flop synchronizer for the pad levels, one lane per pin.
// Assumes pad levels are asynchronous to clk; adds exactly two cycles of latency.
module gpio_bank_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);

    logic [NPINS-1:0] stage1;
    logic [NPINS-1:0] stage2;
    logic [1:0]       warm;

    // Shift each pad level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    // Count cycles since reset so the latency check never looks into reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             warm <= 2'd0;
        else if (warm != 2'd2)  warm <= warm + 2'd1;
    end

    // R3: the output equals the input of two edges earlier.
    p_two_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_bank_pinmux.sv
// Module: per-pin output source select, inversion, enable and open-drain shaping,
// plus input gating. Combinational; clk/rst_n serve only the checks beside the logic.
module gpio_bank_pinmux #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] func,
    input  logic [NPINS-1:0] oval,
    input  logic [NPINS-1:0] oe,
    input  logic [NPINS-1:0] inv,
    input  logic [NPINS-1:0] od,
    input  logic [NPINS-1:0] ie,
    input  logic [NPINS-1:0] per_out,
    input  logic [NPINS-1:0] per_oe,
    input  logic [NPINS-1:0] sync_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] sw_in,
    output logic [NPINS-1:0] per_in
);

    logic [NPINS-1:0] sel_oe;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic sel_v;
        logic drv_v;

        // Pick the owner of the pin and apply the inversion stage.
        always_comb begin
            sel_v     = func[i] ? per_out[i] : oval[i];
            sel_oe[i] = func[i] ? per_oe[i]  : oe[i];
            drv_v     = sel_v ^ inv[i];
        end

        // Shape the pad drive: push-pull, or low-only with release for high.
        always_comb begin
            if (od[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = sel_oe[i] & ~drv_v;
            end else begin
                pad_out[i] = drv_v;
                pad_oe[i]  = sel_oe[i];
            end
        end

        // Gate the synchronized level toward software and the peripheral.
        always_comb begin
            sw_in[i]  = sync_in[i] & ie[i];
            per_in[i] = sync_in[i] & ie[i];
        end
    end

    // R5: no pad is driven unless its selected enable is set.
    p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~sel_oe) == '0));

    // R6: an open-drain pin never presents a high drive value.
    p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((od & pad_out) == '0));

    // R2: a disabled input never shows a 1 to either consumer.
    p_ie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (((sw_in | per_in) & ~ie) == '0));

    // R1: with software controls steady, software-owned pins ignore the peripheral.
    p_gpio_ignores_periph_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(func) && $stable(oval) && $stable(oe) && $stable(inv) && $stable(od)) |->
        ((((pad_out ^ $past(pad_out)) | (pad_oe ^ $past(pad_oe))) & ~func) == '0));

endmodule

// File: rtl/gpio_bank_ctl.sv
// Module: top of the GPIO pin control cell; ties the register file, the input
// synchronizer and the per-pin multiplexer together. Assumes NPINS <= DATA_W.
module gpio_bank_ctl
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_oe,
    input  logic [NPINS-1:0]      per_out,
    input  logic [NPINS-1:0]      per_oe,
    output logic [NPINS-1:0]      per_in
);

    logic [NPINS-1:0] ie_q, oe_q, oval_q, inv_q, func_q, od_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] sw_in;

    gpio_bank_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .in_value (sw_in),
        .ie_q     (ie_q),
        .oe_q     (oe_q),
        .oval_q   (oval_q),
        .inv_q    (inv_q),
        .func_q   (func_q),
        .od_q     (od_q),
        .rdata    (reg_rdata)
    );

    gpio_bank_sync #(.NPINS(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    gpio_bank_pinmux #(.NPINS(NPINS)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .func    (func_q),
        .oval    (oval_q),
        .oe      (oe_q),
        .inv     (inv_q),
        .od      (od_q),
        .ie      (ie_q),
        .per_out (per_out),
        .per_oe  (per_oe),
        .sync_in (sync_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .sw_in   (sw_in),
        .per_in  (per_in)
    );

    // R8: right after a reset cycle no pad is driven.
    p_reset_undriven_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0));

endmodule

// File: tb/gpio_bank_ctl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctl_test;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pad_in, pad_out, pad_oe;
    logic [NP-1:0] per_out = '0, per_oe = '0, per_in;
    logic [NP-1:0] ext_level = '1;   // pull-up / external level when a pad is released

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    // Modelled tri-state pad: driven value when enabled, otherwise the external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_level);

    gpio_bank_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
        .per_in(per_in)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic clear_all();
        for (int a = 1; a <= 6; a++) wr(3'(a), '0);
        per_out = '0; per_oe = '0; ext_level = '1;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // R8: reset state of registers, pads and input value.
    task automatic t_reset();
        logic [31:0] v;
        ext_level = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pad_oe, '0, "R8 pad_oe after reset");
        for (int a = 0; a <= 6; a++) begin
            rd(3'(a), v);
            chk(v, '0, "R8 register clear");
        end
        chk(per_in, '0, "R8 per_in after reset");
    endtask

    // R7: register map, read-only input value, unmapped index.
    task automatic t_regmap();
        logic [31:0] v;
        for (int a = 1; a <= 6; a++) wr(3'(a), 32'h0101_0000 * a + 32'h0000_5A00 + a);
        for (int a = 1; a <= 6; a++) begin
            rd(3'(a), v);
            chk(v, 32'h0101_0000 * a + 32'h0000_5A00 + a, "R7 readback");
        end
        clear_all();
        wr(3'd0, 32'hFFFF_FFFF);
        for (int a = 0; a <= 6; a++) begin
            rd(3'(a), v);
            chk(v, '0, "R7 write to read-only index ignored");
        end
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd7, v);
        chk(v, '0, "R7 unmapped index reads 0");
        clear_all();
    endtask

    // R1 R2 R4 R5: every combination of function, input enable, invert, enable on pin 0.
    task automatic t_combos();
        logic [31:0] v;
        for (int c = 0; c < 16; c++) begin
            for (int d = 0; d < 2; d++) begin
                logic fen, ie, inv, oe, sel, drv, lvl;
                fen = c[3]; ie = c[2]; inv = c[1]; oe = c[0];
                per_out = {31'd0, ~d[0]};
                per_oe  = {31'd0, oe};
                wr(3'd5, {31'd0, fen});
                wr(3'd1, {31'd0, ie});
                wr(3'd4, {31'd0, inv});
                wr(3'd3, {31'd0, d[0]});
                wr(3'd2, {31'd0, fen ? ~oe : oe});
                settle();
                sel = fen ? ~d[0] : d[0];
                drv = sel ^ inv;
                lvl = oe ? drv : 1'b1;
                chk({31'd0, pad_oe[0]}, {31'd0, oe}, "R5/R1 pin0 enable");
                if (oe) chk({31'd0, pad_out[0]}, {31'd0, drv}, "R4/R1 pin0 value");
                rd(3'd0, v);
                chk({31'd0, v[0]}, {31'd0, ie & lvl}, "R2 pin0 read value");
                chk({31'd0, per_in[0]}, {31'd0, ie & lvl}, "R2 pin0 per_in");
            end
        end
        clear_all();
    endtask

    // R3: input level reaches the readable value after exactly two edges.
    task automatic t_sync();
        logic [31:0] v;
        wr(3'd1, 32'h0000_0020);
        ext_level[5] = 1'b0;
        settle();
        rd(3'd0, v);
        chk({31'd0, v[5]}, 32'd0, "R3 pin5 settled low");
        @(negedge clk);
        ext_level[5] = 1'b1;
        @(negedge clk);
        rd(3'd0, v);
        chk({31'd0, v[5]}, 32'd0, "R3 one edge not yet visible");
        @(negedge clk);
        rd(3'd0, v);
        chk({31'd0, v[5]}, 32'd1, "R3 visible after two edges");
        chk({31'd0, per_in[5]}, 32'd1, "R3 per_in after two edges");
        clear_all();
    endtask

    // R6: open-drain shaping in software and peripheral mode.
    task automatic t_open_drain();
        logic [31:0] v;
        wr(3'd6, 32'h0000_1F00);          // pins 8..12 open-drain
        wr(3'd1, 32'h0000_1F00);
        wr(3'd2, 32'h0000_0700);          // pins 8..10 enabled, 11 disabled
        wr(3'd3, 32'h0000_0A00);          // pin9=1, pin11=1
        wr(3'd4, 32'h0000_0400);          // pin10 inverted
        wr(3'd5, 32'h0000_1000);          // pin12 peripheral
        per_oe = 32'h0000_1000; per_out = 32'h0000_1000;
        settle();
        chk(pad_out & 32'h0000_1F00, '0, "R6 open-drain never drives high");
        // drv: p8=0, p9=1, p10=1, p11=1 (disabled), p12=1 -> only pin 8 pulls low
        chk(pad_oe & 32'h0000_1F00, 32'h0000_0100, "R6 open-drain enables");
        rd(3'd0, v);
        chk(v & 32'h0000_1F00, 32'h0000_1E00, "R6 released pins read high");
        @(negedge clk);
        per_out = '0;
        settle();
        chk(pad_oe & 32'h0000_1F00, 32'h0000_1100, "R6 peripheral pin pulls low");
        rd(3'd0, v);
        chk(v & 32'h0000_1F00, 32'h0000_0E00, "R6 peripheral low read back");
        clear_all();
    endtask

    // R1 R4 R5: whole-bank mixed pattern.
    task automatic t_bank();
        logic [31:0] f, o, e, iv, po, pe, eoe, eout, v;
        f = 32'hA5A5_0F0F; o = 32'h1234_5678; iv = 32'h0FF0_F00F;
        e = 32'hFFFF_0000; po = 32'hCAFE_BABE; pe = 32'h00FF_FF00;
        per_out = po; per_oe = pe;
        wr(3'd5, f); wr(3'd3, o); wr(3'd4, iv); wr(3'd2, e); wr(3'd1, 32'hFFFF_FFFF);
        settle();
        eoe  = (f & pe) | (~f & e);
        eout = ((f & po) | (~f & o)) ^ iv;
        chk(pad_oe, eoe, "R5/R1 bank enables");
        chk(pad_out, eout, "R4/R1 bank values");
        rd(3'd0, v);
        chk(v, (eoe & eout) | ~eoe, "R2 bank read value");
        @(negedge clk);
        per_out = ~po; per_oe = ~pe;
        @(negedge clk);
        chk(pad_out & ~f, eout & ~f, "R1 software pins ignore peripheral");
        chk(pad_oe & ~f, eoe & ~f, "R1 software enables ignore peripheral");
        clear_all();
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_combos();
        t_sync();
        t_open_drain();
        t_bank();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule